// File: doc/BRIEF.md
# Serial Command and Fault-Diagnosis Slave

This block is the serial control port of a multi-channel load switch. An external controller runs 16-bit frames over a four-wire serial bus. The first four bits of a frame are a command code and the remaining twelve are data. The commands write the regulator settings, the channel options and the channel on/off bits. Every frame also returns a 16-bit diagnosis word on the serial output, so the controller reads the fault state while it writes.

Per-channel fault codes arrive from analog comparators that sit outside this block. A code is latched into the diagnosis register only after it has held steady for a programmable number of system clocks. While any channel code is latched, an active-low fault flag is driven. The diagnosis word is frozen into the transmit register when chip select falls. The channel codes are cleared when chip select rises, and only if the frame just received was a valid command.

All bus pins are synchronised into the system clock domain. Bus clock edges are detected there, so SCLK must run well below the system clock; each SCLK level has to last for at least four system clocks.

Top module: `spi_diag_if`

## Requirements
- R1: A frame is 16 bits and travels MSB first on both data lines. Bits 15:12 are the command and bits 11:0 are the data. A frame is valid only if exactly 16 sample edges occur while chip select is low and the command is one of the codes 1 to 7.
- R2: With `edge_sel_i` low, SI is sampled on the rising edge of SCLK and SO changes on the falling edge. With `edge_sel_i` high, these two edges are swapped. The first shift edge after chip select falls does not shift.
- R3: While chip select is high, SCLK and SI are ignored and `so_oe_o` is low. When chip select falls, the diagnosis word is copied into the transmit register, `so_oe_o` goes high and `so_o` presents bit 15.
- R4: A valid frame takes effect when chip select rises. Command 1, 2 or 3 loads regulator k (k = 1..3) from data[11:1] into `reg_cfg_o[(k-1)*11 +: 11]`, with the layout {mode[1:0], peak[1:0], hold[1:0], off_time[1:0], peak_time[2:0]}.
- R5: An invalid frame (an undefined code, or not exactly 16 clocks) changes no register and does not clear the diagnosis register.
- R6: The diagnosis word holds channel c (1..6) at bits [2c+3:2c+2], so channel 6 is at bits 15:14. Bit 3 is the channel over-temperature flag, bit 2 is the die over-temperature flag, and bits 1:0 are always 11. The channel codes are 11 normal, 10 overload/over-temperature, 01 open load and 00 switch bypassed.
- R7: A non-normal code on `fault_code_i[2c-1:2c-2]` is latched only after the same code has been present for FILT_CYC consecutive clocks. A shorter fault is never latched.
- R8: A newer fault that passes the filter on a channel that already holds a latched fault overwrites the older code.
- R9: `fault_n_o` is low whenever a channel code other than 11 is latched. It returns high after the diagnosis register is cleared.
- R10: A valid frame clears all channel codes to 11 and restarts the filters. Bit 3 is not cleared by this; it follows `ch_ot_i` once that input has held for FILT_CYC clocks. Bit 2 follows `ic_ot_i` one clock late.
- R11: Command 4 loads {`glob_cfg_o`, `olsb_off_o`, `lowside_o`} from data[11:3]. Command 7 loads `ch_on_o` from data[5:0]. Command 5 restores every register to its reset value.
- R12: Command 6 returns the diagnosis word and clears the codes, but ignores its data and changes no register.
- R13: After reset, every regulator field equals 11'h12D, all other configuration outputs are zero, `fault_n_o` is high and `so_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| edge_sel_i | input | 1 | Selects which SCLK edge samples SI |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for SO (low means high impedance) |
| fault_code_i | input | 12 | Raw 2-bit fault code per channel, channel 1 in bits 1:0 |
| ch_ot_i | input | 1 | Raw channel over-temperature indication |
| ic_ot_i | input | 1 | Raw die over-temperature indication |
| fault_n_o | output | 1 | Active-low fault flag |
| reg_cfg_o | output | 33 | Three 11-bit regulator settings |
| glob_cfg_o | output | 3 | {diag6 pin select, latch on over-temp, AND combine} |
| olsb_off_o | output | 3 | Open-load/bypass detection disabled, channels 6..4 |
| lowside_o | output | 3 | Low-side configuration, channels 6..4 |
| ch_on_o | output | 6 | Channel on bits, channel 6..1 |

## Verification
The hardest case to reach is a fault that is latched while the frames around it are a mix of valid and invalid ones. The bench latches a code through the filter and restores the input to normal. It then sends an undefined code and a 15-clock frame that carries an otherwise valid command. Both must leave the latched word in place. A following valid frame must return that same word and then release the flag. A second thread holds the over-temperature input and checks that bit 3 survives two valid clears in a row. The same frames are repeated with the opposite clock edge selection.

// File: rtl/spi_diag_pkg.sv
package spi_diag_pkg;
  localparam int FRAME_W = 16;
  localparam int NUM_CH  = 6;
  localparam int CODE_W  = 2;
  localparam int NUM_REG = 3;
  localparam int REG_W   = 11;
  localparam int CNT_W   = $clog2(FRAME_W + 1) + 1;

  localparam logic [CODE_W-1:0] CODE_OK = 2'b11;
  localparam logic [REG_W-1:0]  REG_RST = 11'h12D;

  typedef enum logic [3:0] {
    CMD_REG1    = 4'h1,
    CMD_REG2    = 4'h2,
    CMD_REG3    = 4'h3,
    CMD_CHCFG   = 4'h4,
    CMD_DEFAULT = 4'h5,
    CMD_DIAG    = 4'h6,
    CMD_ONOFF   = 4'h7
  } cmd_e;

  function automatic logic cmd_defined(input logic [3:0] c);
    return (c >= 4'h1) && (c <= 4'h7);
  endfunction
endpackage

// File: rtl/sdi_sync.sv
module sdi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic si_i,
  input  logic edge_sel_i,
  output logic rst_n_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic cs_idle_o,
  output logic samp_o,
  output logic shift_o,
  output logic si_o
);
  logic [STAGES-1:0] rst_q;
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] sclk_q;
  logic [STAGES-1:0] si_q;
  logic              cs_d;
  logic              sclk_d;
  logic              cs_s;
  logic              sclk_s;
  logic              active;
  logic              sclk_rise;
  logic              sclk_fall;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_q <= '0;
    else         rst_q <= {rst_q[STAGES-2:0], 1'b1};
  end
  assign rst_n_o = rst_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n_o) begin
    if (!rst_n_o) begin
      cs_q   <= '1;
      sclk_q <= '0;
      si_q   <= '0;
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_q   <= {cs_q[STAGES-2:0], cs_n_i};
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      si_q   <= {si_q[STAGES-2:0], si_i};
      cs_d   <= cs_q[STAGES-1];
      sclk_d <= sclk_q[STAGES-1];
    end
  end

  assign cs_s      = cs_q[STAGES-1];
  assign sclk_s    = sclk_q[STAGES-1];
  assign active    = ~cs_s & ~cs_d;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  assign cs_fall_o = cs_d & ~cs_s;
  assign cs_rise_o = ~cs_d & cs_s;
  assign cs_idle_o = cs_d & cs_s;
  assign samp_o    = active & (edge_sel_i ? sclk_fall : sclk_rise);
  assign shift_o   = active & (edge_sel_i ? sclk_rise : sclk_fall);
  assign si_o      = si_q[STAGES-1];
endmodule

// File: rtl/sdi_shifter.sv
module sdi_shifter
  import spi_diag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_fall_i,
  input  logic               cs_rise_i,
  input  logic               samp_i,
  input  logic               shift_i,
  input  logic               si_i,
  input  logic [FRAME_W-1:0] snap_i,
  output logic               so_o,
  output logic               so_oe_o,
  output logic [FRAME_W-1:0] rx_o,
  output logic               len_ok_o
);
  logic [FRAME_W-1:0] tx_q, tx_n;
  logic [FRAME_W-1:0] rx_q, rx_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               oe_q, oe_n;

  always_comb begin
    tx_n  = tx_q;
    rx_n  = rx_q;
    cnt_n = cnt_q;
    oe_n  = oe_q;
    if (cs_fall_i) begin
      tx_n  = snap_i;
      rx_n  = '0;
      cnt_n = '0;
      oe_n  = 1'b1;
    end else if (cs_rise_i) begin
      oe_n = 1'b0;
    end else begin
      if (samp_i) begin
        rx_n = {rx_q[FRAME_W-2:0], si_i};
        if (cnt_q != '1) cnt_n = cnt_q + 1'b1;
      end
      // bit 15 is already on the line before the first sample
      if (shift_i && (cnt_q != '0)) tx_n = {tx_q[FRAME_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '1;
      rx_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      tx_q  <= tx_n;
      rx_q  <= rx_n;
      cnt_q <= cnt_n;
      oe_q  <= oe_n;
    end
  end

  assign so_o     = tx_q[FRAME_W-1];
  assign so_oe_o  = oe_q;
  assign rx_o     = rx_q;
  assign len_ok_o = (cnt_q == CNT_W'(FRAME_W));
endmodule

// File: rtl/sdi_cmd_regs.sv
module sdi_cmd_regs
  import spi_diag_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit_i,
  input  logic                     len_ok_i,
  input  logic [FRAME_W-1:0]       frame_i,
  output logic [NUM_REG*REG_W-1:0] reg_cfg_o,
  output logic [2:0]               glob_o,
  output logic [2:0]               olsb_off_o,
  output logic [2:0]               lowside_o,
  output logic [NUM_CH-1:0]        ch_on_o,
  output logic                     clr_o
);
  localparam int CHCFG_W = 9;

  logic [3:0]          cmd;
  logic [11:0]         data;
  logic                valid;
  logic                to_default;
  logic [CHCFG_W-1:0]  chcfg_q, chcfg_n;
  logic [NUM_CH-1:0]   on_q, on_n;

  assign cmd        = frame_i[FRAME_W-1 -: 4];
  assign data       = frame_i[11:0];
  assign valid      = commit_i & len_ok_i & cmd_defined(cmd);
  assign to_default = valid && (cmd == CMD_DEFAULT);
  assign clr_o      = valid;

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    logic [REG_W-1:0] q, n;
    always_comb begin
      n = q;
      if (to_default) n = REG_RST;
      else if (valid && (cmd == 4'(int'(CMD_REG1) + k))) n = data[11:1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= REG_RST;
      else        q <= n;
    end
    assign reg_cfg_o[k*REG_W +: REG_W] = q;
  end

  always_comb begin
    chcfg_n = chcfg_q;
    on_n    = on_q;
    if (to_default) begin
      chcfg_n = '0;
      on_n    = '0;
    end else if (valid && (cmd == CMD_CHCFG)) begin
      chcfg_n = data[11:3];
    end else if (valid && (cmd == CMD_ONOFF)) begin
      on_n = data[NUM_CH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chcfg_q <= '0;
      on_q    <= '0;
    end else begin
      chcfg_q <= chcfg_n;
      on_q    <= on_n;
    end
  end

  assign glob_o     = chcfg_q[8:6];
  assign olsb_off_o = chcfg_q[5:3];
  assign lowside_o  = chcfg_q[2:0];
  assign ch_on_o    = on_q;
endmodule

// File: rtl/sdi_diag.sv
module sdi_diag
  import spi_diag_pkg::*;
#(
  parameter int FILT_CYC = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*CODE_W-1:0] code_i,
  input  logic                     ch_ot_i,
  input  logic                     ic_ot_i,
  input  logic                     clr_i,
  output logic [FRAME_W-1:0]       word_o,
  output logic                     fault_n_o
);
  localparam int             CW   = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0]  LAST = CW'(FILT_CYC - 1);
  localparam logic [CW-1:0]  FULL = CW'(FILT_CYC);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] raw;
    logic [CODE_W-1:0] prev_q;
    logic [CODE_W-1:0] lat_q, lat_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic              held;

    assign raw  = code_i[c*CODE_W +: CODE_W];
    assign held = (raw != CODE_OK) && (raw == prev_q);

    always_comb begin
      lat_n = lat_q;
      cnt_n = cnt_q;
      if (clr_i) begin
        lat_n = CODE_OK;
        cnt_n = '0;
      end else if (!held) begin
        cnt_n = '0;
      end else if (cnt_q == LAST) begin
        cnt_n = FULL;
        lat_n = raw;
      end else if (cnt_q < LAST) begin
        cnt_n = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= CODE_OK;
        lat_q  <= CODE_OK;
        cnt_q  <= '0;
      end else begin
        prev_q <= raw;
        lat_q  <= lat_n;
        cnt_q  <= cnt_n;
      end
    end

    assign word_o[4 + c*CODE_W +: CODE_W] = lat_q;
  end

  logic [CW-1:0] ot_cnt_q, ot_cnt_n;
  logic          ot_flag_q, ot_flag_n;
  logic          ic_q;

  always_comb begin
    ot_cnt_n  = ot_cnt_q;
    ot_flag_n = ot_flag_q;
    if (!ch_ot_i) begin
      ot_cnt_n  = '0;
      ot_flag_n = 1'b0;
    end else if (ot_cnt_q == LAST) begin
      ot_cnt_n  = FULL;
      ot_flag_n = 1'b1;
    end else if (ot_cnt_q < LAST) begin
      ot_cnt_n = ot_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ot_cnt_q  <= '0;
      ot_flag_q <= 1'b0;
      ic_q      <= 1'b0;
    end else begin
      ot_cnt_q  <= ot_cnt_n;
      ot_flag_q <= ot_flag_n;
      ic_q      <= ic_ot_i;
    end
  end

  assign word_o[3:0] = {ot_flag_q, ic_q, 2'b11};
  assign fault_n_o   = &word_o[FRAME_W-1:4];
endmodule

// File: rtl/spi_diag_if.sv
module spi_diag_if
  import spi_diag_pkg::*;
#(
  parameter int FILT_CYC    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n_i,
  input  logic                     sclk_i,
  input  logic                     si_i,
  input  logic                     edge_sel_i,
  output logic                     so_o,
  output logic                     so_oe_o,
  input  logic [NUM_CH*CODE_W-1:0] fault_code_i,
  input  logic                     ch_ot_i,
  input  logic                     ic_ot_i,
  output logic                     fault_n_o,
  output logic [NUM_REG*REG_W-1:0] reg_cfg_o,
  output logic [2:0]               glob_cfg_o,
  output logic [2:0]               olsb_off_o,
  output logic [2:0]               lowside_o,
  output logic [NUM_CH-1:0]        ch_on_o
);
  logic               rst_n_s;
  logic               cs_fall;
  logic               cs_rise;
  logic               cs_idle;
  logic               samp;
  logic               shft;
  logic               si_s;
  logic [FRAME_W-1:0] snap_word;
  logic [FRAME_W-1:0] rx_frame;
  logic               len_ok;
  logic               diag_clr;

  sdi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .cs_n_i     (cs_n_i),
    .sclk_i     (sclk_i),
    .si_i       (si_i),
    .edge_sel_i (edge_sel_i),
    .rst_n_o    (rst_n_s),
    .cs_fall_o  (cs_fall),
    .cs_rise_o  (cs_rise),
    .cs_idle_o  (cs_idle),
    .samp_o     (samp),
    .shift_o    (shft),
    .si_o       (si_s)
  );

  sdi_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_fall_i (cs_fall),
    .cs_rise_i (cs_rise),
    .samp_i    (samp),
    .shift_i   (shft),
    .si_i      (si_s),
    .snap_i    (snap_word),
    .so_o      (so_o),
    .so_oe_o   (so_oe_o),
    .rx_o      (rx_frame),
    .len_ok_o  (len_ok)
  );

  sdi_cmd_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .commit_i   (cs_rise),
    .len_ok_i   (len_ok),
    .frame_i    (rx_frame),
    .reg_cfg_o  (reg_cfg_o),
    .glob_o     (glob_cfg_o),
    .olsb_off_o (olsb_off_o),
    .lowside_o  (lowside_o),
    .ch_on_o    (ch_on_o),
    .clr_o      (diag_clr)
  );

  sdi_diag #(.FILT_CYC(FILT_CYC)) u_diag (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .code_i    (fault_code_i),
    .ch_ot_i   (ch_ot_i),
    .ic_ot_i   (ic_ot_i),
    .clr_i     (diag_clr),
    .word_o    (snap_word),
    .fault_n_o (fault_n_o)
  );
endmodule

// File: rtl/sdi_checker.sv
module sdi_checker
  import spi_diag_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cs_fall,
  input logic                     cs_idle,
  input logic                     commit,
  input logic                     clr,
  input logic                     snap_msb,
  input logic                     so_o,
  input logic                     so_oe_o,
  input logic                     fault_n_o,
  input logic [NUM_REG*REG_W-1:0] reg_cfg_o,
  input logic [NUM_CH-1:0]        ch_on_o,
  input logic [8:0]               chan_cfg
);
  p_hiz_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |-> !so_oe_o);

  p_drive_on_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> so_oe_o);

  p_snap_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (so_o == $past(snap_msb)));

  p_invalid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !clr) |=> ($stable(reg_cfg_o) && $stable(ch_on_o) && $stable(chan_cfg)));

  p_cfg_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_cfg_o) |-> $past(clr));

  p_fault_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n_o) |-> $past(clr));
endmodule

bind spi_diag_if sdi_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .cs_fall   (cs_fall),
  .cs_idle   (cs_idle),
  .commit    (cs_rise),
  .clr       (diag_clr),
  .snap_msb  (snap_word[15]),
  .so_o      (so_o),
  .so_oe_o   (so_oe_o),
  .fault_n_o (fault_n_o),
  .reg_cfg_o (reg_cfg_o),
  .ch_on_o   (ch_on_o),
  .chan_cfg  ({glob_cfg_o, olsb_off_o, lowside_o})
);

// File: tb/test_spi_diag_if.sv
module test_spi_diag_if;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;
  localparam int FILT       = 32;
  localparam int NVEC       = 10;

  // vector: {frame[15:0], output select[1:0], expected[32:0]}
  // select 0: reg_cfg_o, 1: {glob,olsb,lowside}, 2: ch_on_o
  localparam logic [50:0] VEC [NVEC] = '{
    {16'h1DB4, 2'd0, {11'h12D, 11'h12D, 11'h6DA}},  // R1 R4 regulator 1
    {16'h34CF, 2'd0, {11'h267, 11'h12D, 11'h6DA}},  // R4 regulator 3
    {16'h4D5F, 2'd1, 33'h1AB},                      // R11 channel config
    {16'h7AA9, 2'd2, 33'h29},                       // R11 on/off, upper data ignored
    {16'h9FFF, 2'd2, 33'h29},                       // R5 undefined code
    {16'h6FFF, 2'd0, {11'h267, 11'h12D, 11'h6DA}},  // R12 diag only
    {16'h5000, 2'd0, {3{11'h12D}}},                 // R11 defaults
    {16'h6000, 2'd1, 33'h0},                        // R11 defaults, channel config
    {16'h2000, 2'd0, {11'h12D, 11'h000, 11'h12D}},  // R4 regulator 2
    {16'hF000, 2'd2, 33'h0}                         // R5 undefined code
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n;
  logic        sclk;
  logic        si;
  logic        es;
  logic        so;
  logic        so_oe;
  logic [11:0] codes;
  logic        ch_ot;
  logic        ic_ot;
  logic        fault_n;
  logic [32:0] reg_cfg;
  logic [2:0]  glob_cfg;
  logic [2:0]  olsb_off;
  logic [2:0]  lowside;
  logic [5:0]  ch_on;
  logic [15:0] rx;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_diag_if #(.FILT_CYC(FILT)) i_spi_diag_if (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n),
    .sclk_i       (sclk),
    .si_i         (si),
    .edge_sel_i   (es),
    .so_o         (so),
    .so_oe_o      (so_oe),
    .fault_code_i (codes),
    .ch_ot_i      (ch_ot),
    .ic_ot_i      (ic_ot),
    .fault_n_o    (fault_n),
    .reg_cfg_o    (reg_cfg),
    .glob_cfg_o   (glob_cfg),
    .olsb_off_o   (olsb_off),
    .lowside_o    (lowside),
    .ch_on_o      (ch_on)
  );

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rd);
    logic idle;
    idle = ~es;
    rd   = '0;
    sclk = idle;
    wait_clk(HALF_SCK);
    cs_n = 1'b0;
    wait_clk(HALF_SCK);
    for (int i = 0; i < nbits; i++) begin
      si   = tx[15-i];
      sclk = ~idle;
      wait_clk(HALF_SCK);
      rd[15-i] = so;
      sclk = idle;
      wait_clk(HALF_SCK);
    end
    cs_n = 1'b1;
    wait_clk(HALF_SCK);
  endtask

  function automatic string vtag(input int i);
    case (i)
      0:       return "R1";
      4, 9:    return "R5";
      5:       return "R12";
      2, 3, 6, 7: return "R11";
      default: return "R4";
    endcase
  endfunction

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    wait_clk(100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sclk  = 1'b1;
    si    = 1'b0;
    es    = 1'b0;
    codes = 12'hFFF;
    ch_ot = 1'b0;
    ic_ot = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(8);

    // R13 reset state
    chk("R13 fault_n", 33'(fault_n), 33'h1);
    chk("R13 so_oe", 33'(so_oe), 33'h0);
    chk("R13 reg_cfg", reg_cfg, {3{11'h12D}});
    chk("R13 chan cfg", 33'({glob_cfg, olsb_off, lowside}), 33'h0);
    chk("R13 ch_on", 33'(ch_on), 33'h0);

    // R3 high impedance while idle, SCLK ignored
    sclk = 1'b0; wait_clk(4); sclk = 1'b1; wait_clk(8);
    chk("R3 idle so_oe", 33'(so_oe), 33'h0);
    chk("R3 idle ch_on", 33'(ch_on), 33'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [32:0] got;
      spi_xfer(VEC[i][50:35], 16, rx);
      case (VEC[i][34:33])
        2'd0:    got = reg_cfg;
        2'd1:    got = 33'({glob_cfg, olsb_off, lowside});
        default: got = 33'(ch_on);
      endcase
      chk(vtag(i), got, VEC[i][32:0]);
    end

    // R3 select without clocks: driven, MSB of clean word
    cs_n = 1'b0; wait_clk(8);
    chk("R3 oe on select", 33'(so_oe), 33'h1);
    chk("R3 msb on select", 33'(so), 33'h1);
    cs_n = 1'b1; wait_clk(8);
    chk("R3 oe off", 33'(so_oe), 33'h0);

    // R6 clean word
    spi_xfer(16'h6000, 16, rx);
    chk("R6 clean word", 33'(rx), 33'hFFF3);

    // R7 short fault on channel 1 is filtered
    codes[1:0] = 2'b10; wait_clk(FILT/3); codes = 12'hFFF; wait_clk(10);
    chk("R7 glitch fault_n", 33'(fault_n), 33'h1);

    // R9 open load on channel 2 latched
    codes[3:2] = 2'b01; wait_clk(FILT + 20); codes = 12'hFFF; wait_clk(5);
    chk("R9 fault low", 33'(fault_n), 33'h0);

    // R5 undefined code: returns word, does not clear
    spi_xfer(16'h9000, 16, rx);
    chk("R6 word ch2 open", 33'(rx), 33'hFF73);
    chk("R5 not cleared", 33'(fault_n), 33'h0);

    // R10 valid diag-only clears; R12 data ignored
    spi_xfer(16'h6ABC, 16, rx);
    chk("R10 word kept until valid", 33'(rx), 33'hFF73);
    chk("R9 fault released", 33'(fault_n), 33'h1);
    chk("R12 regs unchanged", reg_cfg, {11'h12D, 11'h000, 11'h12D});
    spi_xfer(16'h6000, 16, rx);
    chk("R10 cleared word", 33'(rx), 33'hFFF3);

    // R8 newer fault overwrites on channel 5
    codes[9:8] = 2'b10; wait_clk(FILT + 20);
    codes[9:8] = 2'b00; wait_clk(FILT + 20);
    codes = 12'hFFF; wait_clk(5);
    spi_xfer(16'h6000, 16, rx);
    chk("R8 overwrite", 33'(rx), 33'hCFF3);

    // R1 15-clock frame with valid code is rejected
    codes[5:4] = 2'b10; wait_clk(FILT + 20); codes = 12'hFFF; wait_clk(5);
    spi_xfer(16'h703F, 15, rx);
    chk("R1 short frame ch_on", 33'(ch_on), 33'h0);
    chk("R5 short frame fault", 33'(fault_n), 33'h0);
    spi_xfer(16'h703F, 16, rx);
    chk("R5 word survived short", 33'(rx), 33'hFEF3);
    chk("R11 ch_on loaded", 33'(ch_on), 33'h3F);

    // R10 temperature flags
    ic_ot = 1'b1; ch_ot = 1'b1; wait_clk(FILT + 20);
    spi_xfer(16'h6000, 16, rx);
    chk("R10 both ot flags", 33'(rx), 33'hFFFF);
    spi_xfer(16'h6000, 16, rx);
    chk("R10 ot flag survives clear", 33'(rx), 33'hFFFF);
    ic_ot = 1'b0; ch_ot = 1'b0; wait_clk(5);
    spi_xfer(16'h6000, 16, rx);
    chk("R10 flags drop", 33'(rx), 33'hFFF3);

    // R2 opposite edge selection
    es = 1'b1; sclk = 1'b0; wait_clk(8);
    spi_xfer(16'h7015, 16, rx);
    chk("R2 write ch_on", 33'(ch_on), 33'h15);
    chk("R2 read clean", 33'(rx), 33'hFFF3);
    codes[1:0] = 2'b01; wait_clk(FILT + 20); codes = 12'hFFF; wait_clk(5);
    spi_xfer(16'h6000, 16, rx);
    chk("R2 read ch1 open", 33'(rx), 33'hFFD3);
    es = 1'b0; sclk = 1'b1; wait_clk(8);

    // R11 defaults restore
    spi_xfer(16'h5000, 16, rx);
    chk("R11 default ch_on", 33'(ch_on), 33'h0);
    chk("R11 default regs", reg_cfg, {3{11'h12D}});

    finish_run();
  end
endmodule